// File: doc/BRIEF.md
# Frame Reassembly CRC Checker

This block sits on the receive side of a cell-based link. It takes payload segments of 48 bytes, one per transfer, each tagged with the end-of-frame flag carried in its cell header. It rebuilds the frame boundaries from that flag alone. It also keeps a 34-bit CRC running across every segment of the frame. Before the first frame bit, the CRC is fed the receiver's own address, so a frame whose checksum is intact but which was delivered to the wrong receiver still fails.

Payload bytes go out one per transfer on a byte stream, and the final data byte carries a last marker. The trailer of the end segment holds a pad-length field and the received CRC. Pad bytes and trailer are consumed and not forwarded. When the end segment has been processed, the block raises a one-cycle verdict with an accept bit, three reject reasons and the number of data bytes forwarded. Lost or false end flags need no special path: the frame merged or split by them is judged by whatever trailer closes it. The block does not buffer frames, so the consumer discards the bytes of a rejected frame.

Both streams are valid/ready. A segment is taken on a clock edge where `seg_valid` and `seg_ready` are both high. The source must keep `seg_valid`, `seg_data` and `seg_end` steady until that edge. `seg_ready` is high only while no segment is being worked on. A byte moves on an edge where `byte_valid` and `byte_ready` are both high. While `byte_valid` is high and `byte_ready` is low, `byte_data` and `byte_last` do not change. A stalled consumer stalls only the data bytes; pad bytes and the trailer are consumed one per cycle regardless. The verdict pins are plain and cannot be stalled.

Top module: `frame_crc_checker`

## Requirements
- R1: Within a segment, byte 0 is `seg_data[383:376]` and byte 47 is `seg_data[7:0]`. Forwarded bytes leave in ascending byte order. A segment whose end flag is clear forwards all 48 bytes. `seg_ready` drops on the cycle after a segment is accepted.
- R2: While `byte_valid` is high and `byte_ready` is low, `byte_valid`, `byte_data` and `byte_last` stay unchanged. No byte is lost or repeated under stalls.
- R3: A frame is every segment accepted since the previous end-flagged segment, up to and including the next segment with `seg_end` = 1. `byte_last` is high only on the final forwarded data byte of that segment. That byte is delivered before the verdict is raised.
- R4: The CRC register starts at zero. Each bit is shifted in MSB first: feedback = reg[33] XOR bit, reg = reg<<1, XOR with the polynomial (default 0x23B550A6D) if feedback is 1. The bits are taken in this order: the `ADDR_W` bits of `my_addr` from the MSB down, then every frame bit in byte order up to but not including the final 34 bits. Any mismatch with the received field sets reject reason bit 0.
- R5: In the end segment, byte 43 bits 7:2 (`seg_data[39:34]`) hold the pad length p. `seg_data[33:0]` holds the received CRC.
- R6: For p <= 42, bytes 43-p..42 of the end segment are pad. They are not forwarded. The reported count is 48*n - 5 - p for a frame of n segments.
- R7: A pad length above 42 sets reject reason bit 1. For such a frame, bytes 0..42 of the end segment are forwarded and the count is 48*n - 5.
- R8: A frame of more than `MAX_SEGS` segments (default 1366) sets reject reason bit 2. Exactly `MAX_SEGS` segments does not.
- R9: A frame whose CRC was computed with an address other than `my_addr` is rejected with reason bit 0.
- R10: `verdict_valid` is a single-cycle pulse, one per frame. `verdict_ok` is high exactly when no reject reason is set.
- R11: If a frame's end flag is lost, its segments and those of the next frame form one frame, checked against the later trailer.
- R12: A false end flag splits a frame into pieces. Each piece gets its own verdict from the bytes in its own trailer position.
- R13: During and right after reset, `seg_ready` is high and `byte_valid` and `verdict_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_addr | input | ADDR_W | Receiver address, fed to the CRC ahead of each frame |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment can be taken |
| seg_data | input | 384 | Segment payload, byte 0 in the top bits |
| seg_end | input | 1 | End-of-frame flag from the cell header |
| byte_valid | output | 1 | Data byte offered |
| byte_ready | input | 1 | Consumer takes the byte |
| byte_data | output | 8 | Data byte |
| byte_last | output | 1 | Final data byte of the frame |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_ok | output | 1 | Frame accepted |
| verdict_flags | output | 3 | Reject reasons: bit2 too long, bit1 bad pad, bit0 CRC mismatch |
| verdict_count | output | CNT_W | Data bytes forwarded for the frame (saturating) |

## Verification
The bench aims at the pad extremes: 0 and 42, and a pad field of 50. A design that took the pad length from the wrong bits, or counted pad bytes as data, would forward the wrong bytes and report the wrong count. The bench also checks the frame length exactly at the segment limit and one segment past it, which catches an off-by-one in the size check.

The bench runs a frame with a lost end flag and a frame with a false end flag. A design that carried CRC state across a verdict, or ended frames on anything but the flag, would accept merged data or produce the wrong number of verdicts. It also sends a correct frame with the wrong receiver address and a frame with a single flipped bit; a design that skipped the address prefix would accept the misdelivered frame. Finally, it runs a multi-segment frame under a stalling consumer, which exposes a design that drops or repeats bytes when `byte_ready` is low.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;
  localparam int CRC_W = 34;
  localparam int PAD_W = 6;
  localparam logic [CRC_W-1:0] CRC_POLY_DEFAULT = 34'h2_3B55_0A6D;

  typedef logic [CRC_W-1:0] crc_t;

  typedef struct packed {
    logic oversize;
    logic pad_bad;
    logic crc_bad;
  } reject_t;

  // Shift one octet (or only its top PAD_W bits) into the CRC, MSB first.
  function automatic crc_t crc_feed(crc_t state, logic [7:0] octet,
                                    logic top_only, crc_t poly);
    crc_t c;
    logic fb;
    c = state;
    for (int i = 0; i < 8; i++) begin
      if (!(top_only && i >= PAD_W)) begin
        fb = c[CRC_W-1] ^ octet[7-i];
        c  = {c[CRC_W-2:0], 1'b0};
        if (fb) c = c ^ poly;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/frame_crc_engine.sv
module frame_crc_engine
  import frame_crc_pkg::*;
#(
  parameter int   ADDR_W = 24,
  parameter crc_t POLY   = CRC_POLY_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic              step,
  input  logic              first,
  input  logic              top_only,
  input  logic [7:0]        octet,
  output crc_t              crc_next
);
  crc_t seed;
  crc_t crc_q;
  crc_t crc_base;

  // Address prefix folded into a starting value for every frame.
  always_comb begin
    logic fb;
    seed = '0;
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      fb   = seed[CRC_W-1] ^ rx_addr[i];
      seed = {seed[CRC_W-2:0], 1'b0};
      if (fb) seed = seed ^ POLY;
    end
  end

  assign crc_base = first ? seed : crc_q;
  assign crc_next = crc_feed(crc_base, octet, top_only, POLY);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= '0;
    else if (step) crc_q <= crc_next;
  end
endmodule

// File: rtl/frame_seg_walker.sv
module frame_seg_walker
  import frame_crc_pkg::*;
#(
  parameter int SEG_BYTES = 48
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seg_valid,
  output logic                   seg_ready,
  input  logic [SEG_BYTES*8-1:0] seg_data,
  input  logic                   seg_end,
  output logic                   byte_valid,
  input  logic                   byte_ready,
  output logic [7:0]             byte_data,
  output logic                   byte_last,
  output logic                   seg_take,
  output logic                   step,
  output logic                   first,
  output logic                   top_only,
  output logic                   frame_end,
  output crc_t                   crc_rx,
  output logic                   pad_bad
);
  localparam int SEG_W    = SEG_BYTES * 8;
  localparam int IDX_W    = $clog2(SEG_BYTES);
  localparam int SEL_W    = $clog2(SEG_W);
  localparam int TRL_IDX  = SEG_BYTES - 5;
  localparam int DATA_MAX = SEG_BYTES - 6;

  logic             busy;
  logic             end_q;
  logic             in_frame;
  logic [SEG_W-1:0] seg_q;
  logic [IDX_W-1:0] idx;
  logic [PAD_W-1:0] pad_len;
  logic [PAD_W-1:0] pad_eff;
  logic [IDX_W-1:0] data_last;
  logic [SEL_W-1:0] bit_pos;
  logic             fwd;
  logic             advance;
  logic             at_trl;
  logic             seg_done;

  assign seg_ready = !busy;
  assign seg_take  = seg_valid && !busy;

  assign pad_len   = seg_q[CRC_W +: PAD_W];
  assign crc_rx    = seg_q[CRC_W-1:0];
  assign pad_bad   = pad_len > PAD_W'(DATA_MAX);
  assign pad_eff   = pad_bad ? '0 : pad_len;
  assign data_last = end_q ? IDX_W'(DATA_MAX) - IDX_W'(pad_eff)
                           : IDX_W'(SEG_BYTES - 1);

  assign bit_pos   = SEL_W'(SEG_W - 8) - (SEL_W'(idx) << 3);
  assign byte_data = seg_q[bit_pos +: 8];

  assign fwd        = idx <= data_last;
  assign byte_valid = busy && fwd;
  assign byte_last  = byte_valid && end_q && (idx == data_last);
  assign advance    = busy && (!fwd || byte_ready);
  assign at_trl     = end_q && (idx == IDX_W'(TRL_IDX));
  assign seg_done   = advance && (end_q ? at_trl : (idx == IDX_W'(SEG_BYTES - 1)));

  assign step      = advance;
  assign first     = !in_frame;
  assign top_only  = at_trl;
  assign frame_end = seg_done && end_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      end_q    <= 1'b0;
      in_frame <= 1'b0;
      seg_q    <= '0;
      idx      <= '0;
    end else begin
      if (seg_take) begin
        busy  <= 1'b1;
        seg_q <= seg_data;
        end_q <= seg_end;
        idx   <= '0;
      end else if (advance) begin
        idx <= idx + 1'b1;
        if (seg_done) busy <= 1'b0;
      end
      if (frame_end)    in_frame <= 1'b0;
      else if (advance) in_frame <= 1'b1;
    end
  end

  // R2
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data) && $stable(byte_last));

  // R1
  take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_ready |=> !seg_ready);
endmodule

// File: rtl/frame_verdict.sv
module frame_verdict
  import frame_crc_pkg::*;
#(
  parameter int MAX_SEGS = 1366,
  parameter int CNT_W    = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_take,
  input  logic             byte_fire,
  input  logic             byte_fire_last,
  input  logic             frame_end,
  input  crc_t             crc_calc,
  input  crc_t             crc_rx,
  input  logic             pad_bad,
  output logic             verdict_valid,
  output logic             verdict_ok,
  output logic [2:0]       verdict_flags,
  output logic [CNT_W-1:0] verdict_count
);
  localparam int SCNT_W = $clog2(MAX_SEGS + 2);
  localparam logic [SCNT_W-1:0] SEG_CAP = SCNT_W'(MAX_SEGS + 1);

  logic [SCNT_W-1:0] seg_cnt;
  logic [CNT_W-1:0]  byte_cnt;
  logic              seen_last;
  reject_t           why;

  assign why.oversize = seg_cnt > SCNT_W'(MAX_SEGS);
  assign why.pad_bad  = pad_bad;
  assign why.crc_bad  = crc_calc != crc_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_cnt       <= '0;
      byte_cnt      <= '0;
      seen_last     <= 1'b0;
      verdict_valid <= 1'b0;
      verdict_ok    <= 1'b0;
      verdict_flags <= '0;
      verdict_count <= '0;
    end else begin
      verdict_valid <= frame_end;
      if (frame_end) begin
        verdict_ok    <= (why == '0);
        verdict_flags <= why;
        verdict_count <= byte_cnt;
        seg_cnt       <= '0;
        byte_cnt      <= '0;
        seen_last     <= 1'b0;
      end else begin
        if (seg_take && seg_cnt != SEG_CAP) seg_cnt <= seg_cnt + 1'b1;
        if (byte_fire && byte_cnt != '1)   byte_cnt <= byte_cnt + 1'b1;
        if (byte_fire_last)                seen_last <= 1'b1;
      end
    end
  end

  // R3
  last_before_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> seen_last);

  // R10
  verdict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid);
endmodule

// File: rtl/frame_crc_checker.sv
module frame_crc_checker
  import frame_crc_pkg::*;
#(
  parameter int   ADDR_W    = 24,
  parameter int   SEG_BYTES = 48,
  parameter int   MAX_SEGS  = 1366,
  parameter crc_t POLY      = CRC_POLY_DEFAULT,
  localparam int  CNT_W     = $clog2(SEG_BYTES * MAX_SEGS + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      my_addr,
  input  logic                   seg_valid,
  output logic                   seg_ready,
  input  logic [SEG_BYTES*8-1:0] seg_data,
  input  logic                   seg_end,
  output logic                   byte_valid,
  input  logic                   byte_ready,
  output logic [7:0]             byte_data,
  output logic                   byte_last,
  output logic                   verdict_valid,
  output logic                   verdict_ok,
  output logic [2:0]             verdict_flags,
  output logic [CNT_W-1:0]       verdict_count
);
  logic seg_take, step, first, top_only, frame_end, pad_bad;
  crc_t crc_rx, crc_calc;

  frame_seg_walker #(.SEG_BYTES(SEG_BYTES)) u_walker (
    .clk, .rst_n, .seg_valid, .seg_ready, .seg_data, .seg_end,
    .byte_valid, .byte_ready, .byte_data, .byte_last,
    .seg_take, .step, .first, .top_only, .frame_end, .crc_rx, .pad_bad
  );

  frame_crc_engine #(.ADDR_W(ADDR_W), .POLY(POLY)) u_engine (
    .clk, .rst_n, .rx_addr(my_addr), .step, .first, .top_only,
    .octet(byte_data), .crc_next(crc_calc)
  );

  frame_verdict #(.MAX_SEGS(MAX_SEGS), .CNT_W(CNT_W)) u_verdict (
    .clk, .rst_n, .seg_take,
    .byte_fire(byte_valid && byte_ready),
    .byte_fire_last(byte_last && byte_ready),
    .frame_end, .crc_calc, .crc_rx, .pad_bad,
    .verdict_valid, .verdict_ok, .verdict_flags, .verdict_count
  );
endmodule

// File: tb/frame_crc_checker_bench.sv
module frame_crc_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int SEGB   = 48;
  localparam int MAXS   = 6;
  localparam int NIMG   = 8 * SEGB;
  localparam int CNT_W  = $clog2(SEGB * MAXS + 1) + 1;
  localparam logic [33:0] POLY = 34'h2_3B55_0A6D;
  localparam logic [ADDR_W-1:0] ADDR_A = 24'h3A_51C7;
  localparam logic [ADDR_W-1:0] ADDR_B = 24'h3A_51C6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] my_addr = ADDR_A;
  logic seg_valid = 1'b0;
  logic seg_ready;
  logic [SEGB*8-1:0] seg_data = '0;
  logic seg_end = 1'b0;
  logic byte_valid;
  logic byte_ready = 1'b1;
  logic [7:0] byte_data;
  logic byte_last;
  logic verdict_valid, verdict_ok;
  logic [2:0] verdict_flags;
  logic [CNT_W-1:0] verdict_count;

  int n_chk = 0, n_bad = 0;
  int stall_on = 0;
  logic [7:0] img [0:NIMG-1];
  logic [7:0] rx_b [0:NIMG-1];
  logic       rx_l [0:NIMG-1];
  int rx_n = 0;
  logic       v_ok [0:7];
  logic [2:0] v_fl [0:7];
  int         v_cnt [0:7];
  int v_n = 0;

  frame_crc_checker #(.ADDR_W(ADDR_W), .SEG_BYTES(SEGB), .MAX_SEGS(MAXS)) u_frame_crc_checker (
    .clk, .rst_n, .my_addr, .seg_valid, .seg_ready, .seg_data, .seg_end,
    .byte_valid, .byte_ready, .byte_data, .byte_last,
    .verdict_valid, .verdict_ok, .verdict_flags, .verdict_count
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid && byte_ready && rx_n < NIMG) begin
        rx_b[rx_n] = byte_data; rx_l[rx_n] = byte_last; rx_n++;
      end
      if (verdict_valid) begin
        if (v_n < 8) begin
          v_ok[v_n] = verdict_ok; v_fl[v_n] = verdict_flags; v_cnt[v_n] = int'(verdict_count);
        end
        v_n++;
      end
    end
  end

  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      k++;
      byte_ready = stall_on != 0 ? ((k % 3) != 0) : 1'b1;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 60000, 0);
    summary();
    $finish;
  end

  task automatic check(input bit good, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [33:0] crc_model(input logic [ADDR_W-1:0] a, input int start, input int nbytes);
    logic [33:0] c = '0;
    logic b;
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      b = c[33] ^ a[i]; c = {c[32:0], 1'b0}; if (b) c ^= POLY;
    end
    for (int k = 0; k < nbytes; k++) begin
      for (int i = 0; i < ((k == nbytes - 1) ? 6 : 8); i++) begin
        b = c[33] ^ img[start + k][7 - i]; c = {c[32:0], 1'b0}; if (b) c ^= POLY;
      end
    end
    return c;
  endfunction

  task automatic make_frame(input int start, input int nseg, input int pad, input int seed,
                            input logic [ADDR_W-1:0] a);
    int tot = SEGB * nseg;
    int tb = start + tot - 5;
    logic [33:0] c;
    for (int i = 0; i < tot - 5; i++) img[start + i] = 8'((seed * 29 + i * 13 + (i >> 2)) & 255);
    img[tb] = {6'(pad), 2'b00};
    c = crc_model(a, start, tot - 4);
    img[tb][1:0] = c[33:32];
    img[tb + 1] = c[31:24]; img[tb + 2] = c[23:16];
    img[tb + 3] = c[15:8];  img[tb + 4] = c[7:0];
  endtask

  task automatic send_seg(input int s, input bit e);
    @(posedge clk); #1;
    seg_valid = 1'b1; seg_end = e;
    for (int b = 0; b < SEGB; b++) seg_data[(SEGB - 1 - b) * 8 +: 8] = img[s * SEGB + b];
    forever begin
      @(negedge clk);
      if (seg_ready) break;
    end
    @(posedge clk); #1;
    seg_valid = 1'b0;
  endtask

  // Sends nseg segments of img, END flags per mask, and checks every resulting frame.
  task automatic run_image(input string name, input int nseg, input logic [7:0] mask,
                           input logic [ADDR_W-1:0] a);
    int npieces = $countones(mask);
    int pstart = 0, off = 0, k = 0;
    rx_n = 0; v_n = 0; my_addr = a;
    for (int s = 0; s < nseg; s++) send_seg(s, mask[s]);
    for (int w = 0; w < 400 && v_n < npieces; w++) @(negedge clk);
    repeat (5) @(negedge clk);
    for (int s = 0; s < nseg; s++) begin
      if (mask[s]) begin
        int n = s - pstart + 1;
        int base = pstart * SEGB;
        int tb = base + n * SEGB - 5;
        int p = int'(img[tb][7:2]);
        logic [33:0] rx_crc = {img[tb][1:0], img[tb + 1], img[tb + 2], img[tb + 3], img[tb + 4]};
        logic [2:0] fl;
        int pe, cnt, dbad = 0, lbad = 0;
        fl[0] = crc_model(a, base, n * SEGB - 4) != rx_crc;
        fl[1] = p > 42;
        fl[2] = n > MAXS;
        pe = fl[1] ? 0 : p;
        cnt = n * SEGB - 5 - pe;
        if (k < v_n && k < 8) begin
          check(v_fl[k] == fl, {name, " R4/R7/R8 flags"}, v_fl[k], fl);
          check(v_ok[k] == (fl == 0), {name, " R10 ok"}, v_ok[k], fl == 0);
          check(v_cnt[k] == cnt, {name, " R6 count"}, v_cnt[k], cnt);
        end
        for (int i = 0; i < cnt; i++) begin
          if (off + i >= rx_n || rx_b[off + i] != img[base + i]) dbad++;
          else if (rx_l[off + i] != (i == cnt - 1)) lbad++;
        end
        check(dbad == 0, {name, " R1 bytes"}, dbad, 0);
        check(lbad == 0, {name, " R3 last"}, lbad, 0);
        off += cnt; k++; pstart = s + 1;
      end
    end
    check(v_n == npieces, {name, " R10 verdicts"}, v_n, npieces);
    check(rx_n == off, {name, " R2 byte total"}, rx_n, off);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(seg_ready == 1'b1, "R13 seg_ready", seg_ready, 1);
    check(byte_valid == 1'b0, "R13 byte_valid", byte_valid, 0);
    check(verdict_valid == 1'b0, "R13 verdict_valid", verdict_valid, 0);
  endtask

  task automatic t_single_good();
    make_frame(0, 1, 3, 1, ADDR_A);
    run_image("single R5", 1, 8'b1, ADDR_A);
    check(v_ok[0] == 1'b1, "R4 single accepted", v_ok[0], 1);
  endtask

  task automatic t_multi_stall();
    stall_on = 1;
    make_frame(0, 3, 19, 2, ADDR_A);
    run_image("stall R2", 3, 8'b100, ADDR_A);
    stall_on = 0;
  endtask

  task automatic t_wrong_addr();
    make_frame(0, 2, 10, 3, ADDR_A);
    run_image("addr R9", 2, 8'b10, ADDR_B);
    check(v_fl[0][0] == 1'b1, "R9 crc flag", v_fl[0][0], 1);
  endtask

  task automatic t_corrupt();
    make_frame(0, 2, 0, 4, ADDR_A);
    img[50] ^= 8'h10;
    run_image("corrupt R4", 2, 8'b10, ADDR_A);
    check(v_fl[0][0] == 1'b1, "R4 crc flag", v_fl[0][0], 1);
  endtask

  task automatic t_pad_edges();
    make_frame(0, 1, 42, 5, ADDR_A);
    run_image("pad42 R6", 1, 8'b1, ADDR_A);
    check(v_cnt[0] == 1, "R6 pad42 count", v_cnt[0], 1);
    make_frame(0, 1, 0, 6, ADDR_A);
    run_image("pad0 R6", 1, 8'b1, ADDR_A);
    check(v_cnt[0] == 43, "R6 pad0 count", v_cnt[0], 43);
  endtask

  task automatic t_pad_bad();
    make_frame(0, 2, 50, 7, ADDR_A);
    run_image("padbad R7", 2, 8'b10, ADDR_A);
    check(v_fl[0] == 3'b010, "R7 pad flag only", v_fl[0], 2);
  endtask

  task automatic t_merged();
    make_frame(0, 2, 7, 8, ADDR_A);
    make_frame(2 * SEGB, 2, 11, 9, ADDR_A);
    run_image("merged R11", 4, 8'b1000, ADDR_A);
    check(v_ok[0] == 1'b0, "R11 merged rejected", v_ok[0], 0);
    make_frame(0, 1, 4, 10, ADDR_A);
    run_image("after merge R11", 1, 8'b1, ADDR_A);
  endtask

  task automatic t_split();
    make_frame(0, 3, 5, 11, ADDR_A);
    run_image("split R12", 3, 8'b101, ADDR_A);
    check(v_ok[0] == 1'b0 && v_ok[1] == 1'b0, "R12 both pieces rejected", {v_ok[0], v_ok[1]}, 0);
  endtask

  task automatic t_length_limit();
    make_frame(0, MAXS, 20, 12, ADDR_A);
    run_image("at limit R8", MAXS, 8'b1 << (MAXS - 1), ADDR_A);
    check(v_fl[0][2] == 1'b0, "R8 at limit", v_fl[0][2], 0);
    make_frame(0, MAXS + 1, 9, 13, ADDR_A);
    run_image("over limit R8", MAXS + 1, 8'b1 << MAXS, ADDR_A);
    check(v_fl[0][2] == 1'b1, "R8 over limit", v_fl[0][2], 1);
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_single_good();
    t_multi_stall();
    t_wrong_addr();
    t_corrupt();
    t_pad_edges();
    t_pad_bad();
    t_merged();
    t_split();
    t_length_limit();
    summary();
    $finish;
  end
endmodule